// File: doc/BRIEF.md
# SPI Serial EEPROM Command Master

This block turns single host requests into complete command sequences for a 512-byte serial EEPROM on an SPI bus. The host puts an operation code, a 9-bit byte address and, for writes, a data byte on the request inputs, and pulses `start`. The block then drives chip select, serial clock and serial data out, and samples serial data in. It returns read data together with a one-cycle `done` pulse. Four operations are supported: byte read, byte write, status read and status write.

Both write operations get a separate write-enable command first. Chip select is released for a short programmable gap between that command and the write command. After the write command the bus stays quiet for a long programmable wait, which covers the device's internal programming time. The block holds `busy` for the whole sequence, including that wait.

The serial clock half-period, the short gap and the post-write wait are parameters counted in system clock cycles. The ninth address bit is carried inside the instruction byte. A parameter choice of an 8-bit address ties that bit to zero.

Top module: `spi_eeprom_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `spi_wp` is 0, `busy` is 0, `done` is 0, and `spi_rst_ctl` is 1.
- R2: Operation code 0 (byte read) sends one 24-bit frame, MSB first. The frame is the instruction 0000_A011 with A = address bit 8 at bit position 3, then address bits 7..0, then eight 1 bits on `spi_mosi`. At `done`, `rdata` equals the eight `spi_miso` bits sampled during the last eight clock-high phases, first sample in bit 7.
- R3: Operation code 1 (byte write) sends an 8-bit frame 0x06. Chip select then goes high. A 24-bit frame follows: 0000_A010 (A = address bit 8 at bit 3), address bits 7..0, then the write data.
- R4: Operation code 2 (status read) sends one 16-bit frame: 0x05 followed by eight 1 bits. `rdata` at `done` holds the eight bits sampled in that frame's last eight clock-high phases.
- R5: Operation code 3 (status write) sends an 8-bit frame 0x06. Chip select then goes high. A 16-bit frame follows: 0x01, then the write data.
- R6: `spi_mosi` never changes while `spi_sck` is high. Each clock-high phase lasts exactly HALF_CYC system clocks. `spi_sck` is 0 whenever `spi_cs_n` is 1.
- R7: `spi_wp` is 1 during every frame of a byte write or status write, and 0 during read and status-read frames. `spi_rst_ctl` is 1 at all times.
- R8: Chip select stays high for at least GAP_CYC and fewer than WAIT_CYC cycles between the write-enable frame and the write frame. `done` for a write comes no earlier than WAIT_CYC cycles after the write frame ends, with chip select held high until then.
- R9: `busy` is 1 in the cycle after an accepted `start` and stays 1 until `done`. `done` is a single-cycle pulse, and `busy` is 0 in that cycle. For the two read operations, `done` comes exactly one cycle after chip select returns high.
- R10: A `start` pulse while `busy` is 1 is ignored. No extra frame is sent and no extra `done` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted when not busy |
| op | input | 2 | 0 byte read, 1 byte write, 2 status read, 3 status write |
| addr | input | ADDR_W | Byte address (9 bits by default) |
| wdata | input | DATA_W | Byte for a byte write or status write |
| rdata | output | DATA_W | Byte returned by a read, valid with done |
| busy | output | 1 | High while a request sequence is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_wp | output | 1 | Write-protect control, high during write sequences |
| spi_rst_ctl | output | 1 | Reset-control output, held high |

## Verification
`busy` is due in the cycle after the edge that takes `start`. For reads, `done` and `rdata` are due one cycle after chip select rises. The bench samples all outputs on the falling system-clock edge and keeps a cycle counter there. It compares the chip-select rise and the `done` pulse on that counter, and requires a difference of exactly one for reads. The write-enable gap and the post-write wait depend on internal register stages that the requirements do not fix, so those are checked only against the GAP_CYC and WAIT_CYC bounds. Each clock-high phase is counted in system cycles and must equal HALF_CYC.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

   typedef enum logic [1:0] {
      OP_READ    = 2'd0,
      OP_WRITE   = 2'd1,
      OP_STAT_RD = 2'd2,
      OP_STAT_WR = 2'd3
   } ee_op_e;

   localparam logic [7:0] CMD_WREN = 8'h06;
   localparam logic [7:0] CMD_RDSR = 8'h05;
   localparam logic [7:0] CMD_WRSR = 8'h01;
   localparam logic [2:0] RD_TAIL  = 3'b011;
   localparam logic [2:0] WR_TAIL  = 3'b010;

   function automatic logic is_write_op(ee_op_e o);
      return (o == OP_WRITE) || (o == OP_STAT_WR);
   endfunction

endpackage

// File: rtl/spi_wait_timer.sv
module spi_wait_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;
   logic             active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         active  <= 1'b0;
         expired <= 1'b0;
      end else begin
         expired <= 1'b0;
         if (load) begin
            cnt    <= len;
            active <= 1'b1;
         end else if (active) begin
            if (cnt <= CNT_W'(1)) begin
               active  <= 1'b0;
               expired <= 1'b1;
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
         end
      end
   end

   AST_TMR_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !active); // R8
   AST_TMR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      expired |=> !expired); // R8

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
   parameter int HALF_CYC = 2,
   parameter int FRAME_W  = 24,
   parameter int DATA_W   = 8,
   localparam int BIT_W   = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [FRAME_W-1:0] tx,
   input  logic [BIT_W-1:0]   nbits,
   input  logic               miso,
   output logic               cs_n,
   output logic               sck,
   output logic               mosi,
   output logic [DATA_W-1:0]  rx,
   output logic               fin
);

   localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_CYC - 1);

   typedef enum logic [1:0] {E_IDLE, E_LO, E_HI, E_TAIL} eng_st_e;

   eng_st_e            st;
   logic [CNT_W-1:0]   cnt;
   logic [BIT_W-1:0]   bit_i;
   logic [FRAME_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= E_IDLE;
         cnt   <= '0;
         bit_i <= '0;
         sh    <= '0;
         cs_n  <= 1'b1;
         sck   <= 1'b0;
         mosi  <= 1'b0;
         rx    <= '0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         case (st)
            E_IDLE: if (go) begin
               st    <= E_LO;
               cnt   <= '0;
               bit_i <= '0;
               cs_n  <= 1'b0;
               sck   <= 1'b0;
               mosi  <= tx[FRAME_W-1];
               sh    <= {tx[FRAME_W-2:0], 1'b0};
            end
            E_LO: begin
               if (cnt == HALF_LAST) begin
                  cnt <= '0;
                  sck <= 1'b1;
                  st  <= E_HI;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            E_HI: begin
               if (cnt == HALF_LAST) begin
                  cnt <= '0;
                  sck <= 1'b0;
                  rx  <= {rx[DATA_W-2:0], miso};
                  if (bit_i == nbits - BIT_W'(1)) begin
                     st <= E_TAIL;
                  end else begin
                     bit_i <= bit_i + BIT_W'(1);
                     mosi  <= sh[FRAME_W-1];
                     sh    <= {sh[FRAME_W-2:0], 1'b0};
                     st    <= E_LO;
                  end
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            E_TAIL: begin
               if (cnt == HALF_LAST) begin
                  cnt  <= '0;
                  cs_n <= 1'b1;
                  mosi <= 1'b0;
                  fin  <= 1'b1;
                  st   <= E_IDLE;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            default: st <= E_IDLE;
         endcase
      end
   end

   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck); // R6
   AST_SI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi)); // R6
   AST_CS_RISE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (!sck && fin)); // R6

endmodule

// File: rtl/spi_eeprom_master.sv
module spi_eeprom_master
   import spi_ee_pkg::*;
#(
   parameter int ADDR_W   = 9,
   parameter int DATA_W   = 8,
   parameter int HALF_CYC = 2,
   parameter int GAP_CYC  = 8,
   parameter int WAIT_CYC = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              busy,
   output logic              done,
   output logic              spi_cs_n,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_wp,
   output logic              spi_rst_ctl
);

   localparam int FRAME_W = 16 + DATA_W;
   localparam int BIT_W   = $clog2(FRAME_W + 1);
   localparam int TMR_W   = $clog2(WAIT_CYC + 1);
   localparam logic [TMR_W-1:0] GAP_LEN  = TMR_W'(GAP_CYC);
   localparam logic [TMR_W-1:0] WAIT_LEN = TMR_W'(WAIT_CYC);

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("DATA_W must be 8");
      end
      if (ADDR_W < 8 || ADDR_W > 9) begin : g_bad_addr
         $error("ADDR_W must be 8 or 9");
      end
      if (HALF_CYC < 2) begin : g_bad_half
         $error("HALF_CYC must be at least 2");
      end
      if (GAP_CYC < 1 || WAIT_CYC <= GAP_CYC) begin : g_bad_wait
         $error("need 1 <= GAP_CYC < WAIT_CYC");
      end
   endgenerate

   typedef enum logic [2:0] {T_IDLE, T_WREN, T_GAP, T_MAIN, T_POST} top_st_e;

   top_st_e            st;
   ee_op_e             op_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  wdata_q;
   logic               go;
   logic               tmr_load;
   logic               expired;
   logic               fin;
   logic [DATA_W-1:0]  rx;
   logic [FRAME_W-1:0] tx;
   logic [BIT_W-1:0]   nbits;
   logic [TMR_W-1:0]   tmr_len;
   logic               a_hi;

   generate
      if (ADDR_W == 9) begin : g_addr9
         assign a_hi = addr_q[ADDR_W-1];
      end else begin : g_addr8
         assign a_hi = 1'b0;
      end
   endgenerate

   always_comb begin
      tx    = '0;
      nbits = BIT_W'(8);
      if (st == T_WREN) begin
         tx    = {CMD_WREN, {(FRAME_W-8){1'b0}}};
         nbits = BIT_W'(8);
      end else begin
         case (op_q)
            OP_READ: begin
               tx    = {4'b0000, a_hi, RD_TAIL, addr_q[7:0], {DATA_W{1'b1}}};
               nbits = BIT_W'(FRAME_W);
            end
            OP_WRITE: begin
               tx    = {4'b0000, a_hi, WR_TAIL, addr_q[7:0], wdata_q};
               nbits = BIT_W'(FRAME_W);
            end
            OP_STAT_RD: begin
               tx    = {CMD_RDSR, {DATA_W{1'b1}}, 8'h00};
               nbits = BIT_W'(8 + DATA_W);
            end
            OP_STAT_WR: begin
               tx    = {CMD_WRSR, wdata_q, 8'h00};
               nbits = BIT_W'(8 + DATA_W);
            end
         endcase
      end
   end

   assign tmr_len = (st == T_GAP) ? GAP_LEN : WAIT_LEN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= T_IDLE;
         op_q     <= OP_READ;
         addr_q   <= '0;
         wdata_q  <= '0;
         go       <= 1'b0;
         tmr_load <= 1'b0;
         done     <= 1'b0;
         rdata    <= '0;
      end else begin
         go       <= 1'b0;
         tmr_load <= 1'b0;
         done     <= 1'b0;
         case (st)
            T_IDLE: if (start) begin
               op_q    <= ee_op_e'(op);
               addr_q  <= addr;
               wdata_q <= wdata;
               go      <= 1'b1;
               st      <= is_write_op(ee_op_e'(op)) ? T_WREN : T_MAIN;
            end
            T_WREN: if (fin) begin
               st       <= T_GAP;
               tmr_load <= 1'b1;
            end
            T_GAP: if (expired) begin
               st <= T_MAIN;
               go <= 1'b1;
            end
            T_MAIN: if (fin) begin
               if (is_write_op(op_q)) begin
                  st       <= T_POST;
                  tmr_load <= 1'b1;
               end else begin
                  st    <= T_IDLE;
                  done  <= 1'b1;
                  rdata <= rx;
               end
            end
            T_POST: if (expired) begin
               st   <= T_IDLE;
               done <= 1'b1;
            end
            default: st <= T_IDLE;
         endcase
      end
   end

   assign busy        = (st != T_IDLE);
   assign spi_wp      = busy && is_write_op(op_q);
   assign spi_rst_ctl = 1'b1;

   spi_shift_engine #(
      .HALF_CYC (HALF_CYC),
      .FRAME_W  (FRAME_W),
      .DATA_W   (DATA_W)
   ) u_engine (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (go),
      .tx    (tx),
      .nbits (nbits),
      .miso  (spi_miso),
      .cs_n  (spi_cs_n),
      .sck   (spi_sck),
      .mosi  (spi_mosi),
      .rx    (rx),
      .fin   (fin)
   );

   spi_wait_timer #(
      .CNT_W (TMR_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .len     (tmr_len),
      .expired (expired)
   );

   AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy); // R9
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9
   AST_CS_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> spi_cs_n); // R10
   AST_POST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == T_POST || st == T_GAP) |-> spi_cs_n); // R8
   AST_NO_GO_WHILE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> spi_cs_n); // R3

endmodule

// File: tb/spi_eeprom_master_tb.sv
module spi_eeprom_model (
   input  logic cs_n,
   input  logic sck,
   input  logic mosi,
   output logic miso
);
   logic [7:0]  mem [0:511];
   logic [7:0]  sr;
   logic        wel;
   logic [23:0] sh;
   int          nb;
   logic [7:0]  cmd;
   logic [8:0]  a;
   logic [23:0] log_bits [0:63];
   int          log_nb [0:63];
   int          nfr;
   int          si_rd_viol;

   initial begin
      miso = 1'b0; sr = 8'h00; wel = 1'b0; nfr = 0; sh = '0; nb = 0;
      cmd = 8'h00; a = '0; si_rd_viol = 0;
      for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 11);
   end

   always @(negedge cs_n) begin
      nb = 0;
      sh = '0;
   end

   always @(posedge sck) if (!cs_n) begin
      sh = {sh[22:0], mosi};
      nb++;
      if (nb == 8) cmd = sh[7:0];
      if (nb == 16 && cmd[7:4] == 4'h0 && cmd[2:0] == 3'b011) a = {cmd[3], sh[7:0]};
      if (cmd[7:4] == 4'h0 && cmd[2:0] == 3'b011 && nb >= 17 && nb <= 24) begin
         miso = mem[a][24-nb];
         if (!mosi) si_rd_viol++;
      end
      if (cmd == 8'h05 && nb >= 9 && nb <= 16) begin
         miso = sr[16-nb];
         if (!mosi) si_rd_viol++;
      end
   end

   always @(posedge cs_n) if (nb > 0) begin
      if (nfr < 64) begin
         log_bits[nfr] = sh;
         log_nb[nfr]   = nb;
      end
      nfr++;
      if (nb == 8 && sh[7:0] == 8'h06) wel = 1'b1;
      else if (nb == 24 && cmd[7:4] == 4'h0 && cmd[2:0] == 3'b010 && wel) begin
         mem[{cmd[3], sh[15:8]}] = sh[7:0];
         wel = 1'b0;
      end else if (nb == 16 && cmd == 8'h01 && wel) begin
         sr  = sh[7:0];
         wel = 1'b0;
      end
   end
endmodule

module spi_eeprom_master_tb;
   localparam int CLK_P    = 10;
   localparam int HALF_CYC = 2;
   localparam int GAP_CYC  = 8;
   localparam int WAIT_CYC = 200;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] op = 2'd0;
   logic [8:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       busy, done, spi_cs_n, spi_sck, spi_mosi, spi_miso, spi_wp, spi_rst_ctl;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_P/2) clk = ~clk;

   spi_eeprom_master #(
      .ADDR_W(9), .DATA_W(8), .HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC), .WAIT_CYC(WAIT_CYC)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata),
      .rdata(rdata), .busy(busy), .done(done), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_wp(spi_wp), .spi_rst_ctl(spi_rst_ctl)
   );

   spi_eeprom_model u_mem (.cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso));

   // monitor on the falling edge
   int   cyc = 0, cyc_csr = 0, cyc_done = 0, fr = 0, done_cnt = 0, hi_run = 0;
   int   si_chg_viol = 0, sck_idle_viol = 0, hi_viol = 0, dbl_done = 0, rst_viol = 0;
   int   gap_log [0:63];
   logic wp_log [0:63];
   logic [7:0] rd_cap = '0;
   logic prv_sck = 1'b0, prv_mosi = 1'b0, prv_cs = 1'b1, prv_done = 1'b0;

   always @(negedge clk) if (rst_n) begin
      cyc++;
      if (spi_sck && prv_sck && spi_mosi !== prv_mosi) si_chg_viol++;
      if (spi_cs_n && spi_sck) sck_idle_viol++;
      if (spi_sck) hi_run++;
      else begin
         if (prv_sck && hi_run != HALF_CYC) hi_viol++;
         hi_run = 0;
      end
      if (!spi_cs_n && prv_cs) begin
         if (fr < 64) begin
            gap_log[fr] = cyc - cyc_csr;
            wp_log[fr]  = spi_wp;
         end
         fr++;
      end
      if (spi_cs_n && !prv_cs) cyc_csr = cyc;
      if (done) begin
         done_cnt++;
         cyc_done = cyc;
         rd_cap   = rdata;
         if (prv_done) dbl_done++;
      end
      if (spi_rst_ctl !== 1'b1) rst_viol++;
      prv_sck  = spi_sck;
      prv_mosi = spi_mosi;
      prv_cs   = spi_cs_n;
      prv_done = done;
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_range(input string req, input string what, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected %0d..%0d", req, what, act, lo, hi);
      end
   endtask

   logic [7:0] shadow [0:511];

   task automatic do_op(input logic [1:0] o, input logic [8:0] a, input logic [7:0] d, input string req);
      int d0 = done_cnt;
      int t  = 0;
      @(negedge clk);
      start = 1'b1; op = o; addr = a; wdata = d;
      @(negedge clk);
      start = 1'b0;
      chk("R9", "busy after start", busy, 1);
      while (done_cnt == d0 && t < 5000) begin
         @(negedge clk);
         t++;
      end
      chk(req, "one done pulse", done_cnt - d0, 1);
   endtask

   task automatic t_reset();
      chk("R1", "cs_n", spi_cs_n, 1);
      chk("R1", "sck", spi_sck, 0);
      chk("R1", "wp", spi_wp, 0);
      chk("R1", "busy", busy, 0);
      chk("R1", "done", done, 0);
      chk("R1", "rst_ctl", spi_rst_ctl, 1);
   endtask

   task automatic t_read(input logic [8:0] a);
      int i0 = u_mem.nfr;
      do_op(2'd0, a, 8'h00, "R2");
      chk("R2", "frame count", u_mem.nfr - i0, 1);
      chk("R2", "frame bits", u_mem.log_nb[i0], 24);
      chk("R2", "frame value", u_mem.log_bits[i0], {4'b0000, a[8], 3'b011, a[7:0], 8'hFF});
      chk("R2", "rdata", rd_cap, shadow[a]);
      chk("R7", "wp low in read", wp_log[i0], 0);
      chk("R9", "done one cycle after cs rise", cyc_done - cyc_csr, 1);
   endtask

   task automatic t_write(input logic [8:0] a, input logic [7:0] d);
      int i0 = u_mem.nfr;
      do_op(2'd1, a, d, "R3");
      chk("R3", "frame count", u_mem.nfr - i0, 2);
      chk("R3", "wren bits", u_mem.log_nb[i0], 8);
      chk("R3", "wren value", u_mem.log_bits[i0], 24'h000006);
      chk("R3", "write bits", u_mem.log_nb[i0+1], 24);
      chk("R3", "write value", u_mem.log_bits[i0+1], {4'b0000, a[8], 3'b010, a[7:0], d});
      chk("R3", "memory updated", u_mem.mem[a], d);
      chk("R7", "wp in wren", wp_log[i0], 1);
      chk("R7", "wp in write", wp_log[i0+1], 1);
      chk_range("R8", "wren gap", gap_log[i0+1], GAP_CYC, WAIT_CYC - 1);
      chk_range("R8", "post-write wait", cyc_done - cyc_csr, WAIT_CYC, WAIT_CYC + 20);
      shadow[a] = d;
   endtask

   task automatic t_stat_read(input logic [7:0] exp);
      int i0 = u_mem.nfr;
      do_op(2'd2, 9'h000, 8'h00, "R4");
      chk("R4", "frame count", u_mem.nfr - i0, 1);
      chk("R4", "frame bits", u_mem.log_nb[i0], 16);
      chk("R4", "frame value", u_mem.log_bits[i0], 24'h0005FF);
      chk("R4", "rdata", rd_cap, exp);
      chk("R7", "wp low in status read", wp_log[i0], 0);
      chk("R9", "done one cycle after cs rise", cyc_done - cyc_csr, 1);
   endtask

   task automatic t_stat_write(input logic [7:0] d);
      int i0 = u_mem.nfr;
      do_op(2'd3, 9'h000, d, "R5");
      chk("R5", "frame count", u_mem.nfr - i0, 2);
      chk("R5", "wren value", u_mem.log_bits[i0], 24'h000006);
      chk("R5", "wrsr bits", u_mem.log_nb[i0+1], 16);
      chk("R5", "wrsr value", u_mem.log_bits[i0+1], {8'h00, 8'h01, d});
      chk("R5", "status updated", u_mem.sr, d);
      chk("R7", "wp in status write", wp_log[i0+1], 1);
      chk_range("R8", "wren gap", gap_log[i0+1], GAP_CYC, WAIT_CYC - 1);
      chk_range("R8", "post-write wait", cyc_done - cyc_csr, WAIT_CYC, WAIT_CYC + 20);
   endtask

   task automatic t_busy_ignore();
      int i0 = u_mem.nfr;
      int d0 = done_cnt;
      int t  = 0;
      @(negedge clk);
      start = 1'b1; op = 2'd1; addr = 9'h033; wdata = 8'h77;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      start = 1'b1; op = 2'd0; addr = 9'h100;
      @(negedge clk);
      start = 1'b0;
      repeat (150) @(negedge clk);
      start = 1'b1; op = 2'd2;
      @(negedge clk);
      start = 1'b0;
      while (done_cnt == d0 && t < 5000) begin
         @(negedge clk);
         t++;
      end
      repeat (80) @(negedge clk);
      chk("R10", "frames during busy", u_mem.nfr - i0, 2);
      chk("R10", "done pulses", done_cnt - d0, 1);
      chk("R10", "busy after sequence", busy, 0);
      chk("R10", "write kept", u_mem.mem[9'h033], 8'h77);
      shadow[9'h033] = 8'h77;
   endtask

   initial begin : watchdog
      #(CLK_P * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 512; i++) shadow[i] = 8'(i * 37 + 11);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_read(9'h000);
      t_read(9'h1FF);
      t_read(9'h1A5);
      t_write(9'h0A5, 8'h3C);
      t_read(9'h0A5);
      t_write(9'h15A, 8'hC3);
      t_read(9'h15A);
      t_read(9'h05A);
      u_mem.sr = 8'h5A;
      t_stat_read(8'h5A);
      t_stat_write(8'h8C);
      t_stat_read(8'h8C);
      t_busy_ignore();
      t_read(9'h033);
      chk("R6", "mosi changed while sck high", si_chg_viol, 0);
      chk("R6", "sck high with cs high", sck_idle_viol, 0);
      chk("R6", "clock-high phase width", hi_viol, 0);
      chk("R2", "mosi low during read data", u_mem.si_rd_viol, 0);
      chk("R9", "done longer than one cycle", dbl_done, 0);
      chk("R7", "rst_ctl dropped", rst_viol, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule